// File: doc/BRIEF.md
# Extended-precision classifier and tag encoder

This block looks at the eight 80-bit extended-precision stack registers of a floating-point unit. Each register has a sign bit, a 15-bit biased exponent (bias 16383, all ones is the largest code) and a 64-bit significand with an explicit integer bit at position 63. For the register picked by a select input, the block produces the condition-code pattern that an examine operation leaves in the status word. For every register, it also derives the 2-bit tag. All eight tags are packed both into a 16-bit full tag word and into an 8-bit abridged tag byte. In the same transaction, the block unpacks a supplied full tag word and a supplied abridged byte back into per-register empty flags. It does no arithmetic.

A request enters on a valid/ready handshake. The results come out of one register stage, also on a valid/ready handshake. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its results show up with `out_valid` one cycle later. While `out_valid` is high and `out_ready` is low, the output stage holds its contents and `in_ready` stays low. The result is consumed on an edge where both `out_valid` and `out_ready` are high. A new request can be accepted on that same edge.

Top module: `xp_classtag`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: `cc_word` uses only bits 14 (C3), 10 (C2), 9 (C1) and 8 (C0); every other bit is 0. C1 equals the sign bit (bit 79) of the selected register.
- R3: When the selected exponent (bits 78:64) is 0x7FFF, the class bits are 0x0500 if the significand (bits 63:0) is exactly 0x8000000000000000, and 0x0100 otherwise.
- R4: When the selected exponent is 0, the class bits are 0x4000 for a zero significand and 0x4400 otherwise. Any other exponent gives 0x0400, whatever the integer bit holds.
- R5: A register's tag is 3 when its empty flag is 1. Otherwise it is 1 when exponent and significand are both zero, 2 when the exponent is 0 or 0x7FFF or significand bit 63 is 0, and 0 in every other case.
- R6: `tagw_out` holds register i's tag in bits 2i+1:2i (register 7 at bits 15:14, register 0 at bits 1:0).
- R7: `tagb_out` bit i is 1 exactly when register i is not empty.
- R8: `empty_from_w` bit i is 1 exactly when bits 2i+1:2i of `tagw_in` equal 3.
- R9: `empty_from_b` bit i is the inverse of `tagb_in` bit i.
- R10: The results of a request accepted on one edge appear on the outputs with `out_valid` = 1 after the next edge.
- R11: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values.
- R12: `sel_tag` equals the tag (per R5) of the register selected by `sel_in`. The empty flag does not affect `cc_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| regs_flat | input | NREG*80 | Register i in bits 80i+79:80i |
| empty_in | input | NREG | Empty flag per register |
| sel_in | input | log2(NREG) | Register to examine |
| tagw_in | input | 2*NREG | Full tag word to unpack |
| tagb_in | input | NREG | Abridged tag byte to unpack |
| out_valid | output | 1 | Results present |
| out_ready | input | 1 | Results can be consumed |
| cc_word | output | 16 | Examine condition-code pattern |
| sel_tag | output | 2 | Tag of selected register |
| tagw_out | output | 2*NREG | Packed full tag word |
| tagb_out | output | NREG | Packed abridged tag byte |
| empty_from_w | output | NREG | Empty flags unpacked from tagw_in |
| empty_from_b | output | NREG | Empty flags unpacked from tagb_in |

## Verification
The assertions assume that the request fields are known (no X) whenever `in_valid` is high. They also assume that `sel_in` always names an existing register, which holds by construction with the default power-of-two register count. The stimulus drives only fully defined vectors and keeps the select inside the register count. It draws each register value from a class mix of zero, denormal, infinity, NaN, normal and unnormal, so that every condition-code and tag branch is reached often. `out_ready` is toggled at random, so the hold and stall rules are tested under back-pressure.

// File: rtl/xp_pkg.sv
package xp_pkg;
  typedef enum logic [1:0] {
    TAG_LIVE  = 2'd0,
    TAG_ZERO  = 2'd1,
    TAG_ODD   = 2'd2,
    TAG_EMPTY = 2'd3
  } xp_tag_e;

  typedef struct packed {
    logic sign;
    logic exp_max;
    logic exp_zero;
    logic sig_zero;
    logic sig_inf;
    logic int_bit;
  } xp_flags_t;

  localparam int CC_W = 16;
  localparam logic [CC_W-1:0] CC_C0 = 16'h0100;
  localparam logic [CC_W-1:0] CC_C1 = 16'h0200;
  localparam logic [CC_W-1:0] CC_C2 = 16'h0400;
  localparam logic [CC_W-1:0] CC_C3 = 16'h4000;
endpackage

// File: rtl/xp_field_decode.sv
module xp_field_decode
  import xp_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W+MAN_W:0] val,
  output xp_flags_t            flags
);
  localparam int FP_W = EXP_W + MAN_W + 1;
  localparam logic [MAN_W-1:0] SIG_INF = {1'b1, {(MAN_W-1){1'b0}}};

  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] sig;

  assign expo = val[MAN_W +: EXP_W];
  assign sig  = val[MAN_W-1:0];

  always_comb begin
    flags.sign     = val[FP_W-1];
    flags.exp_max  = &expo;
    flags.exp_zero = ~|expo;
    flags.sig_zero = ~|sig;
    flags.sig_inf  = (sig == SIG_INF);
    flags.int_bit  = sig[MAN_W-1];
  end
endmodule

// File: rtl/xp_tag_encode.sv
module xp_tag_encode
  import xp_pkg::*;
(
  input  xp_flags_t flags,
  input  logic      empty,
  output xp_tag_e   tag
);
  always_comb begin
    if (empty)
      tag = TAG_EMPTY;
    else if (flags.exp_zero && flags.sig_zero)
      tag = TAG_ZERO;
    else if (flags.exp_zero || flags.exp_max || !flags.int_bit)
      tag = TAG_ODD;
    else
      tag = TAG_LIVE;
  end
endmodule

// File: rtl/xp_exam_cc.sv
module xp_exam_cc
  import xp_pkg::*;
(
  input  xp_flags_t         flags,
  output logic [CC_W-1:0]   cc
);
  logic [CC_W-1:0] cls;

  always_comb begin
    if (flags.exp_max)
      cls = flags.sig_inf ? (CC_C2 | CC_C0) : CC_C0;
    else if (flags.exp_zero)
      cls = flags.sig_zero ? CC_C3 : (CC_C3 | CC_C2);
    else
      cls = CC_C2;
    cc = cls | (flags.sign ? CC_C1 : '0);
  end
endmodule

// File: rtl/xp_tag_unpack.sv
module xp_tag_unpack #(
  parameter int NREG = 8
) (
  input  logic [2*NREG-1:0] word_in,
  input  logic [NREG-1:0]   abr_in,
  output logic [NREG-1:0]   empty_w,
  output logic [NREG-1:0]   empty_b
);
  for (genvar g = 0; g < NREG; g++) begin : g_field
    assign empty_w[g] = &word_in[2*g +: 2];
    assign empty_b[g] = ~abr_in[g];
  end
endmodule

// File: rtl/xp_classtag.sv
module xp_classtag
  import xp_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [NREG*(EXP_W+MAN_W+1)-1:0]   regs_flat,
  input  logic [NREG-1:0]                   empty_in,
  input  logic [$clog2(NREG)-1:0]           sel_in,
  input  logic [2*NREG-1:0]                 tagw_in,
  input  logic [NREG-1:0]                   tagb_in,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [15:0]                       cc_word,
  output logic [1:0]                        sel_tag,
  output logic [2*NREG-1:0]                 tagw_out,
  output logic [NREG-1:0]                   tagb_out,
  output logic [NREG-1:0]                   empty_from_w,
  output logic [NREG-1:0]                   empty_from_b
);
  localparam int FP_W  = EXP_W + MAN_W + 1;
  localparam int TAG_W = 2 * NREG;

  xp_flags_t         flags [NREG];
  xp_tag_e           tags  [NREG];
  logic [TAG_W-1:0]  tagw_c;
  logic [NREG-1:0]   tagb_c;
  xp_flags_t         sel_flags;
  logic [CC_W-1:0]   cc_c;
  logic [NREG-1:0]   ew_c;
  logic [NREG-1:0]   eb_c;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    xp_field_decode #(.EXP_W(EXP_W), .MAN_W(MAN_W)) dec_i (
      .val   (regs_flat[g*FP_W +: FP_W]),
      .flags (flags[g])
    );
    xp_tag_encode enc_i (
      .flags (flags[g]),
      .empty (empty_in[g]),
      .tag   (tags[g])
    );
    assign tagw_c[2*g +: 2] = tags[g];
    assign tagb_c[g]        = ~empty_in[g];
  end

  assign sel_flags = flags[sel_in];

  xp_exam_cc exam_i (
    .flags (sel_flags),
    .cc    (cc_c)
  );

  xp_tag_unpack #(.NREG(NREG)) unpack_i (
    .word_in (tagw_in),
    .abr_in  (tagb_in),
    .empty_w (ew_c),
    .empty_b (eb_c)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      cc_word      <= '0;
      sel_tag      <= '0;
      tagw_out     <= '0;
      tagb_out     <= '0;
      empty_from_w <= '0;
      empty_from_b <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        cc_word      <= cc_c;
        sel_tag      <= tags[sel_in];
        tagw_out     <= tagw_c;
        tagb_out     <= tagb_c;
        empty_from_w <= ew_c;
        empty_from_b <= eb_c;
      end
    end
  end
endmodule

// File: rtl/xp_classtag_chk.sv
module xp_classtag_chk #(
  parameter int NREG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [15:0]       cc_word,
  input logic [1:0]        sel_tag,
  input logic [2*NREG-1:0] tagw_out,
  input logic [NREG-1:0]   tagb_out,
  input logic [NREG-1:0]   tagb_in,
  input logic [NREG-1:0]   empty_from_b
);
  AST_CC_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((cc_word & ~16'h4700) == 16'h0000)); // R2

  AST_CLASS_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones({cc_word[14], cc_word[10], cc_word[8]}) >= 1)); // R4

  AST_ZERO_TAG_CC: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sel_tag == 2'd1) |-> (cc_word[14] && !cc_word[10] && !cc_word[8])); // R5

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(cc_word) && $stable(sel_tag)
                                   && $stable(tagw_out) && $stable(tagb_out))); // R11

  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R11

  AST_ABR_UNPACK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (empty_from_b == ~$past(tagb_in))); // R9

  for (genvar g = 0; g < NREG; g++) begin : g_pack
    AST_ABR_VS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (tagb_out[g] == (tagw_out[2*g +: 2] != 2'b11))); // R7
  end
endmodule

bind xp_classtag xp_classtag_chk #(.NREG(NREG)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .cc_word      (cc_word),
  .sel_tag      (sel_tag),
  .tagw_out     (tagw_out),
  .tagb_out     (tagb_out),
  .tagb_in      (tagb_in),
  .empty_from_b (empty_from_b)
);

// File: tb/xp_classtag_tb_top.sv
module xp_classtag_tb_top;
  localparam int NR = 8;
  localparam int FW = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [NR*FW-1:0] regs_flat = '0;
  logic [NR-1:0] empty_in = '0;
  logic [2:0] sel_in = '0;
  logic [2*NR-1:0] tagw_in = '0;
  logic [NR-1:0] tagb_in = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [15:0] cc_word;
  logic [1:0] sel_tag;
  logic [2*NR-1:0] tagw_out;
  logic [NR-1:0] tagb_out, empty_from_w, empty_from_b;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic e_v = 1'b0;
  logic [15:0] e_cc, e_tw;
  logic [1:0] e_st;
  logic [7:0] e_tb, e_ew, e_eb;

  always #5 clk = ~clk;

  xp_classtag dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .regs_flat(regs_flat), .empty_in(empty_in), .sel_in(sel_in),
    .tagw_in(tagw_in), .tagb_in(tagb_in), .out_valid(out_valid),
    .out_ready(out_ready), .cc_word(cc_word), .sel_tag(sel_tag),
    .tagw_out(tagw_out), .tagb_out(tagb_out),
    .empty_from_w(empty_from_w), .empty_from_b(empty_from_b)
  );

  function automatic logic [15:0] ref_cc(logic [79:0] v);
    logic [15:0] r = v[79] ? 16'h0200 : 16'h0000;
    if (v[78:64] == 15'h7fff)
      r = r | ((v[63:0] == 64'h8000_0000_0000_0000) ? 16'h0500 : 16'h0100);
    else if (v[78:64] == 15'h0)
      r = r | ((v[63:0] == 64'h0) ? 16'h4000 : 16'h4400);
    else
      r = r | 16'h0400;
    return r;
  endfunction

  function automatic logic [1:0] ref_tag(logic [79:0] v, logic emp);
    if (emp) return 2'd3;
    if (v[78:64] == 0 && v[63:0] == 0) return 2'd1;
    if (v[78:64] == 0 || v[78:64] == 15'h7fff || !v[63]) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [79:0] rand_fp();
    int kind = $urandom_range(0, 5);
    logic [63:0] m = {$urandom, $urandom};
    logic [14:0] e = 15'($urandom_range(1, 32766));
    logic s = 1'($urandom);
    case (kind)
      0: return {s, 15'h0, 64'h0};
      1: return {s, 15'h0, (m == 0) ? 64'h1 : m};
      2: return {s, 15'h7fff, 64'h8000_0000_0000_0000};
      3: return {s, 15'h7fff, m ^ 64'h8000_0000_0000_0000};
      4: return {s, e, 1'b1, m[62:0]};
      default: return {s, e, 1'b0, m[62:0]};
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // One cycle: check outputs against model, drive handshake, advance model.
  task automatic cyc(bit iv, bit ordy);
    chk("R10/R1 out_valid", {15'b0, out_valid}, {15'b0, e_v});
    if (e_v) begin
      chk("R2/R3/R4 cc_word", cc_word, e_cc);
      chk("R12 sel_tag", {14'b0, sel_tag}, {14'b0, e_st});
      chk("R5/R6 tagw_out", tagw_out, e_tw);
      chk("R7 tagb_out", {8'b0, tagb_out}, {8'b0, e_tb});
      chk("R8 empty_from_w", {8'b0, empty_from_w}, {8'b0, e_ew});
      chk("R9 empty_from_b", {8'b0, empty_from_b}, {8'b0, e_eb});
    end
    in_valid = iv;
    out_ready = ordy;
    #1;
    chk("R11 in_ready", {15'b0, in_ready}, {15'b0, (!e_v || ordy)});
    if (iv && (!e_v || ordy)) begin
      e_v = 1'b1;
      e_cc = ref_cc(regs_flat[sel_in*FW +: FW]);
      e_st = ref_tag(regs_flat[sel_in*FW +: FW], empty_in[sel_in]);
      for (int i = 0; i < NR; i++) begin
        e_tw[2*i +: 2] = ref_tag(regs_flat[i*FW +: FW], empty_in[i]);
        e_tb[i] = !empty_in[i];
        e_ew[i] = (tagw_in[2*i +: 2] == 2'd3);
        e_eb[i] = !tagb_in[i];
      end
    end else if (ordy) begin
      e_v = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", {15'b0, out_valid}, 16'h0);
    chk("R1 in_ready in reset", {15'b0, in_ready}, 16'h1);
    rst_n = 1'b1;
    @(negedge clk);
    cyc(1'b0, 1'b1);

    // Directed class set: zero, denormal, +inf, NaN, normal, unnormal, -normal, pseudo-inf
    regs_flat[0*FW +: FW] = {1'b0, 15'h0, 64'h0};
    regs_flat[1*FW +: FW] = {1'b1, 15'h0, 64'h0000_0000_0000_0001};
    regs_flat[2*FW +: FW] = {1'b0, 15'h7fff, 64'h8000_0000_0000_0000};
    regs_flat[3*FW +: FW] = {1'b1, 15'h7fff, 64'hC000_0000_0000_0000};
    regs_flat[4*FW +: FW] = {1'b0, 15'h3fff, 64'h8000_0000_0000_0000};
    regs_flat[5*FW +: FW] = {1'b0, 15'h4000, 64'h4000_0000_0000_0000};
    regs_flat[6*FW +: FW] = {1'b1, 15'h3ffe, 64'hFFFF_0000_0000_0001};
    regs_flat[7*FW +: FW] = {1'b0, 15'h7fff, 64'h0};
    empty_in = 8'b1000_0100;
    tagw_in = 16'hC3FC;
    tagb_in = 8'hA5;
    for (int s = 0; s < NR; s++) begin
      sel_in = 3'(s);
      cyc(1'b1, 1'b1);
    end
    // R12: empty flag on the selected register leaves cc_word as its class
    empty_in = 8'hFF;
    sel_in = 3'd2;
    tagw_in = 16'hFFFF;
    tagb_in = 8'h00;
    cyc(1'b1, 1'b1);
    empty_in = 8'h00;
    tagw_in = 16'h0000;
    tagb_in = 8'hFF;
    cyc(1'b1, 1'b1);
    // R11: back-pressure with pending input
    sel_in = 3'd3;
    cyc(1'b1, 1'b0);
    sel_in = 3'd0;
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b1);
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);

    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < NR; i++) regs_flat[i*FW +: FW] = rand_fp();
      empty_in = 8'($urandom);
      sel_in = 3'($urandom);
      tagw_in = 16'($urandom);
      tagb_in = 8'($urandom);
      cyc(($urandom_range(0, 3) != 0), ($urandom_range(0, 9) < 7));
    end
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule